// File: doc/BRIEF.md
# Multiply/Divide/MAC Coprocessor

This block is an arithmetic helper that sits beside a 16-bit processor and appears to it as sixteen byte-wide registers, selected by a 4-bit index. Software loads operands into four 16-bit working words (A, B, C, D), then writes an operation code to the mode register. The unit runs for a fixed number of clock cycles, and the result appears in the working words. It offers 16x16 multiply, 32/16 and 32/32 divide, and 16x16+32 multiply-accumulate with wrapping or clamping. One mode bit selects two's-complement or unsigned interpretation for every operation.

The working words occupy indices 0..7 as little-endian bytes: A at 0/1, B at 2/3, C at 4/5, D at 6/7. A 32-bit quantity in A:B has A as its low half, and one in C:D has C as its low half. A multiply takes A times B and returns the product in A:B. A divide takes the dividend from A:B and the divisor from C (16-bit form) or from C:D (32-bit form). It returns the quotient in A:B and the remainder in C:D. A multiply-accumulate adds A times B into the accumulator held in C:D and leaves A and B untouched, so a chain of products can be summed by reloading A and B and restarting.

Top module: `arith_cop`

## Requirements
- R1: After reset, indices 0 through 9 read 0x00 and the busy flag is clear.
- R2: Index 15 always reads 0x81, and writes to it have no effect.
- R3: Indices 10 through 14 read 0x00 and ignore writes. The status register at index 9 also ignores writes.
- R4: The mode register at index 8 has the layout bit 7 = signed, bits 2:0 = operation, with 0 multiply, 1 divide 32/16, 2 divide 32/32, 3 accumulate, and 4 saturating accumulate. Writing an operation code of 0 to 4 starts that operation. Status bit 0 (busy) then reads 1 for exactly 4 cycles for multiply and both accumulates, 8 for divide 32/16, and 16 for divide 32/32. The mode register reads back the byte last written to it. Codes 5 to 7 are stored but start nothing.
- R5: While busy is set, CPU writes to every index are ignored.
- R6: Multiply leaves the 32-bit product of A and B in A:B, taking both operands as signed or as unsigned according to the mode bit.
- R7: Divide 32/16 leaves A:B / C in A:B and the remainder in C:D. In signed mode the quotient truncates toward zero and the remainder takes the sign of the dividend. A signed quotient that does not fit wraps modulo 2^32.
- R8: Divide 32/32 behaves as R7, with the divisor taken from C:D.
- R9: A zero divisor sets status bit 1, makes the quotient 0xFFFF_FFFF, and copies the original dividend into C:D.
- R10: Wrapping accumulate writes C:D + A*B modulo 2^32 into C:D, leaves A and B unchanged, and sets no flag.
- R11: Saturating accumulate clamps an out-of-range signed result to 0x7FFF_FFFF when the result is positive and to 0x8000_0000 when it is negative. It clamps an unsigned carry-out to 0xFFFF_FFFF. Each clamp sets status bit 2.
- R12: Starting any operation clears status bits 1 and 2. They are set again only by the operation that raises them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 4 | Register index for read and write |
| wr_en | input | 1 | Write strobe for the byte at reg_idx |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read data of the byte at reg_idx |

## Verification
A wrong busy counter shows up at the status byte at once: the busy flag drops one or more cycles early or late, and the latency check catches it on the first operation of each kind. A fault in the iterative multiplier or divider state is not visible until the completing edge, but it then corrupts the A:B or C:D result of that very operation. Operand sweeps that cross the sign boundaries and the zero cases expose such faults within one run. Flag faults appear at the status byte right after completion. They are caught because every operation in the sweep checks both flags against the values the bench expects.

// File: rtl/acop_pkg.sv
package acop_pkg;

    typedef enum logic [2:0] {
        OP_MUL   = 3'd0,
        OP_DIV16 = 3'd1,
        OP_DIV32 = 3'd2,
        OP_MAC   = 3'd3,
        OP_MACS  = 3'd4
    } op_e;

    localparam int OPW        = 16;
    localparam int WORDW      = 2 * OPW;
    localparam int MUL_CYC    = 4;
    localparam int DIV16_CYC  = 8;
    localparam int DIV32_CYC  = 16;
    localparam int CNT_W      = $clog2(DIV32_CYC + 1);
    localparam int MUL_BPC    = OPW / MUL_CYC;
    localparam int NARROW_BPC = WORDW / DIV16_CYC;
    localparam int WIDE_BPC   = WORDW / DIV32_CYC;

    localparam logic [7:0] ID_DEFAULT = 8'h81;
    localparam logic [3:0] IDX_MODE   = 4'd8;
    localparam logic [3:0] IDX_STAT   = 4'd9;
    localparam logic [3:0] IDX_ID     = 4'd15;

    typedef struct packed {
        logic       sgn;
        logic [3:0] spare;
        logic [2:0] op;
    } mode_t;

    typedef struct packed {
        logic [4:0] zero;
        logic       ovf;
        logic       dz;
        logic       busy;
    } stat_t;

    function automatic logic op_valid(input logic [2:0] op);
        return op <= 3'd4;
    endfunction

    function automatic logic [CNT_W-1:0] op_cycles(input logic [2:0] op);
        case (op)
            OP_DIV16: return CNT_W'(DIV16_CYC);
            OP_DIV32: return CNT_W'(DIV32_CYC);
            default:  return CNT_W'(MUL_CYC);
        endcase
    endfunction

    function automatic logic op_is_div(input logic [2:0] op);
        return (op == OP_DIV16) || (op == OP_DIV32);
    endfunction

endpackage

// File: rtl/acop_seq.sv
module acop_seq
    import acop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cycles,
    output logic             busy,
    output logic             step,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= cycles - 1'b1;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy = busy_q;
        step = busy_q;
        done = busy_q && (cnt_q == '0);
    end

    // R4: busy ends exactly on the completing edge
    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy_q);
    p_busy_count_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
    // R5: a new operation is never accepted while one runs
    p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/acop_mul_unit.sv
module acop_mul_unit
    import acop_pkg::*;
#(
    parameter int W   = OPW,
    parameter int BPC = MUL_BPC
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic           sgn,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [2*W-1:0] prod_next
);

    localparam int RW = 2 * W;

    logic [RW-1:0] mcand_q, acc_q, acc_n;
    logic [W-1:0]  mplr_q, mag_a, mag_b;
    logic          neg_q;

    always_comb begin
        mag_a = (sgn && opa[W-1]) ? -opa : opa;
        mag_b = (sgn && opb[W-1]) ? -opb : opb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            acc_q   <= '0;
            mplr_q  <= '0;
            neg_q   <= 1'b0;
        end else if (load) begin
            mcand_q <= RW'(mag_a);
            mplr_q  <= mag_b;
            acc_q   <= '0;
            neg_q   <= sgn && (opa[W-1] ^ opb[W-1]);
        end else if (step) begin
            acc_q   <= acc_n;
            mcand_q <= mcand_q << BPC;
            mplr_q  <= mplr_q >> BPC;
        end
    end

    always_comb begin
        acc_n     = acc_q + mcand_q * RW'(mplr_q[BPC-1:0]);
        prod_next = neg_q ? -acc_n : acc_n;
    end

endmodule

// File: rtl/acop_div_unit.sv
module acop_div_unit
    import acop_pkg::*;
#(
    parameter int W        = WORDW,
    parameter int BPC_FAST = NARROW_BPC,
    parameter int BPC_SLOW = WIDE_BPC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         sgn,
    input  logic         narrow,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo_next,
    output logic [W-1:0] rem_next
);

    logic [W-1:0] q_q, d_q, q_t;
    logic [W:0]   r_q, r_t;
    logic         qneg_q, rneg_q, narrow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q      <= '0;
            r_q      <= '0;
            d_q      <= '0;
            qneg_q   <= 1'b0;
            rneg_q   <= 1'b0;
            narrow_q <= 1'b0;
        end else if (load) begin
            q_q      <= (sgn && dvd[W-1]) ? -dvd : dvd;
            d_q      <= (sgn && dvs[W-1]) ? -dvs : dvs;
            r_q      <= '0;
            qneg_q   <= sgn && (dvd[W-1] ^ dvs[W-1]);
            rneg_q   <= sgn && dvd[W-1];
            narrow_q <= narrow;
        end else if (step) begin
            q_q <= q_t;
            r_q <= r_t;
        end
    end

    // restoring division, BPC_FAST or BPC_SLOW quotient bits per cycle
    always_comb begin
        q_t = q_q;
        r_t = r_q;
        for (int i = 0; i < BPC_FAST; i++) begin
            if (narrow_q || i < BPC_SLOW) begin
                r_t = {r_t[W-1:0], q_t[W-1]};
                q_t = {q_t[W-2:0], 1'b0};
                if (r_t >= {1'b0, d_q}) begin
                    r_t    = r_t - {1'b0, d_q};
                    q_t[0] = 1'b1;
                end
            end
        end
        quo_next = qneg_q ? -q_t : q_t;
        rem_next = rneg_q ? -r_t[W-1:0] : r_t[W-1:0];
    end

    // R7/R8: partial remainder stays below the divisor
    p_rem_below_r8: assert property (@(posedge clk) disable iff (rst)
        (d_q != '0) |-> (r_q < {1'b0, d_q}));

endmodule

// File: rtl/arith_cop.sv
module arith_cop
    import acop_pkg::*;
#(
    parameter logic [7:0] ID_CODE = ID_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] reg_idx,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);

    logic [3:0][OPW-1:0] wreg_q;
    mode_t               mode_q;
    logic [2:0]          op_q;
    logic                sgn_q, dz_q, ovf_q, dzp_q;
    logic                busy, step, done, cpu_wr_ok, start;
    mode_t               mode_in;
    logic [WORDW-1:0]    ab, cd, dvs_sel, prod, quo, rem;
    logic [WORDW:0]      sum_u;
    logic [WORDW-1:0]    mac_sum, clamp;
    logic                ovf_hit;
    stat_t               stat;

    always_comb begin
        mode_in   = mode_t'(wr_data);
        ab        = wreg_q[1:0];
        cd        = wreg_q[3:2];
        cpu_wr_ok = wr_en && !busy;
        start     = cpu_wr_ok && (reg_idx == IDX_MODE) && op_valid(mode_in.op);
        if (mode_in.op == OP_DIV16)
            dvs_sel = mode_in.sgn ? {{OPW{wreg_q[2][OPW-1]}}, wreg_q[2]}
                                  : {{OPW{1'b0}}, wreg_q[2]};
        else
            dvs_sel = cd;
    end

    acop_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cycles (op_cycles(mode_in.op)),
        .busy   (busy),
        .step   (step),
        .done   (done)
    );

    acop_mul_unit u_mul (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .step      (step),
        .sgn       (mode_in.sgn),
        .opa       (wreg_q[0]),
        .opb       (wreg_q[1]),
        .prod_next (prod)
    );

    acop_div_unit u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .step     (step),
        .sgn      (mode_in.sgn),
        .narrow   (mode_in.op == OP_DIV16),
        .dvd      (ab),
        .dvs      (dvs_sel),
        .quo_next (quo),
        .rem_next (rem)
    );

    // accumulate and clamp
    always_comb begin
        sum_u   = {1'b0, cd} + {1'b0, prod};
        mac_sum = sum_u[WORDW-1:0];
        if (sgn_q)
            ovf_hit = (prod[WORDW-1] == cd[WORDW-1]) && (mac_sum[WORDW-1] != cd[WORDW-1]);
        else
            ovf_hit = sum_u[WORDW];
        if (!sgn_q)
            clamp = '1;
        else if (cd[WORDW-1])
            clamp = {1'b1, {(WORDW-1){1'b0}}};
        else
            clamp = {1'b0, {(WORDW-1){1'b1}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wreg_q <= '0;
            mode_q <= '0;
            op_q   <= OP_MUL;
            sgn_q  <= 1'b0;
            dz_q   <= 1'b0;
            ovf_q  <= 1'b0;
            dzp_q  <= 1'b0;
        end else begin
            if (cpu_wr_ok && !reg_idx[3])
                wreg_q[reg_idx[2:1]][{reg_idx[0], 3'b000} +: 8] <= wr_data;
            if (cpu_wr_ok && reg_idx == IDX_MODE)
                mode_q <= mode_in;
            if (start) begin
                op_q  <= mode_in.op;
                sgn_q <= mode_in.sgn;
                dzp_q <= op_is_div(mode_in.op) && (dvs_sel == '0);
                dz_q  <= 1'b0;
                ovf_q <= 1'b0;
            end
            if (done) begin
                case (op_q)
                    OP_MUL: wreg_q[1:0] <= prod;
                    OP_DIV16, OP_DIV32: begin
                        dz_q <= dzp_q;
                        if (dzp_q) begin
                            wreg_q[1:0] <= '1;
                            wreg_q[3:2] <= ab;
                        end else begin
                            wreg_q[1:0] <= quo;
                            wreg_q[3:2] <= rem;
                        end
                    end
                    OP_MAC: wreg_q[3:2] <= mac_sum;
                    OP_MACS: begin
                        wreg_q[3:2] <= ovf_hit ? clamp : mac_sum;
                        ovf_q       <= ovf_hit;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        stat      = '0;
        stat.busy = busy;
        stat.dz   = dz_q;
        stat.ovf  = ovf_q;
        if (!reg_idx[3])
            rd_data = wreg_q[reg_idx[2:1]][{reg_idx[0], 3'b000} +: 8];
        else if (reg_idx == IDX_MODE)
            rd_data = mode_q;
        else if (reg_idx == IDX_STAT)
            rd_data = stat;
        else if (reg_idx == IDX_ID)
            rd_data = ID_CODE;
        else
            rd_data = 8'h00;
    end

    // R5: CPU-visible state frozen while an operation runs
    p_busy_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(wreg_q) && $stable(mode_q)));
    // R11: overflow flag only from the clamping accumulate, with a clamp value
    p_ovf_clamp_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> (op_q == OP_MACS &&
            (cd == 32'h7FFF_FFFF || cd == 32'h8000_0000 || cd == 32'hFFFF_FFFF)));
    // R9: divide-by-zero flag comes with an all-ones quotient
    p_dz_quot_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(dz_q) |-> (op_is_div(op_q) && ab == 32'hFFFF_FFFF));
    // R12: flags are clear right after a start
    p_flags_clear_r12: assert property (@(posedge clk) disable iff (rst)
        start |=> (!dz_q && !ovf_q));

endmodule

// File: tb/arith_cop_tb.sv
module arith_cop_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_idx = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] v16 [8] = '{16'h0000, 16'h0001, 16'h0003, 16'h7FFF,
                             16'h8000, 16'hFFFF, 16'h1234, 16'hFFFE};
    logic [31:0] v32 [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_0000, 32'h0000_0064};

    arith_cop u_dut (
        .clk     (clk),
        .rst     (rst),
        .reg_idx (reg_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] v);
        reg_idx = idx;
        #1;
        v = rd_data;
    endtask

    task automatic wr32(input logic [3:0] base, input logic [31:0] val);
        for (int k = 0; k < 4; k++) wr(base + 4'(k), val[8*k +: 8]);
    endtask

    task automatic rd32(input logic [3:0] base, output logic [31:0] val);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            rd(base + 4'(k), b);
            val[8*k +: 8] = b;
        end
    endtask

    // R4: start and count busy cycles
    task automatic run_op(input logic [7:0] mode, input int cyc);
        logic [7:0] s;
        int cnt;
        wr(4'd8, mode);
        cnt = 0;
        rd(4'd9, s);
        while (s[0] && cnt < 40) begin
            cnt++;
            @(negedge clk);
            rd(4'd9, s);
        end
        chk("R4 busy cycles", 32'(cnt), 32'(cyc));
    endtask

    task automatic chk_flags(input string tag, input logic dz, input logic ovf);
        logic [7:0] s;
        rd(4'd9, s);
        chk(tag, {24'h0, s}, {29'h0, ovf, dz, 1'b0});
    endtask

    task automatic t_mul(input logic [15:0] a, input logic [15:0] b, input logic sgn);
        longint x, y;
        logic [31:0] got;
        wr32(4'd0, {b, a});
        run_op({sgn, 7'd0}, 4);
        x = sgn ? longint'($signed(a)) : longint'(a);
        y = sgn ? longint'($signed(b)) : longint'(b);
        rd32(4'd0, got);
        chk("R6 product", got, 32'(x * y));
        chk_flags("R12 flags after multiply", 1'b0, 1'b0);
    endtask

    task automatic t_div(input logic [31:0] n, input logic [31:0] d, input logic sgn,
                         input logic wide);
        longint x, y;
        logic [31:0] q, r, eq, er;
        logic dz;
        wr32(4'd0, n);
        wr32(4'd4, d);
        run_op({sgn, 4'd0, wide ? 3'd2 : 3'd1}, wide ? 16 : 8);
        x = sgn ? longint'($signed(n)) : longint'(n);
        if (wide) y = sgn ? longint'($signed(d)) : longint'(d);
        else      y = sgn ? longint'($signed(d[15:0])) : longint'(d[15:0]);
        dz = (y == 0);
        if (dz) begin
            eq = 32'hFFFF_FFFF;
            er = n;
        end else begin
            eq = 32'(x / y);
            er = 32'(x % y);
        end
        rd32(4'd0, q);
        rd32(4'd4, r);
        if (dz) begin
            chk("R9 zero-divisor quotient", q, eq);
            chk("R9 zero-divisor remainder", r, er);
        end else if (wide) begin
            chk("R8 quotient", q, eq);
            chk("R8 remainder", r, er);
        end else begin
            chk("R7 quotient", q, eq);
            chk("R7 remainder", r, er);
        end
        chk_flags("R9 R12 flags after divide", dz, 1'b0);
    endtask

    task automatic t_mac(input logic [15:0] a, input logic [15:0] b, input logic [31:0] acc,
                         input logic sgn, input logic sat);
        longint x, y, s, lo, hi;
        logic [31:0] got, ab, exp;
        logic ov;
        wr32(4'd0, {b, a});
        wr32(4'd4, acc);
        run_op({sgn, 4'd0, sat ? 3'd4 : 3'd3}, 4);
        x  = sgn ? longint'($signed(a)) : longint'(a);
        y  = sgn ? longint'($signed(b)) : longint'(b);
        s  = x * y + (sgn ? longint'($signed(acc)) : longint'(acc));
        lo = sgn ? -64'sd2147483648 : 64'sd0;
        hi = sgn ? 64'sd2147483647 : 64'sd4294967295;
        ov = sat && (s > hi || s < lo);
        exp = ov ? ((s > hi) ? 32'(hi) : 32'(lo)) : 32'(s);
        rd32(4'd4, got);
        rd32(4'd0, ab);
        if (sat) chk("R11 saturating sum", got, exp);
        else     chk("R10 wrapping sum", got, exp);
        chk("R10 operands kept", ab, {b, a});
        chk_flags("R11 R12 flags after accumulate", 1'b0, ov);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 10; i++) begin
            rd(4'(i), b);
            chk("R1 reset value", {24'h0, b}, 32'h0);
        end

        // R2: identity byte
        wr(4'd15, 8'h00);
        rd(4'd15, b);
        chk("R2 identity", {24'h0, b}, 32'h81);

        // R3: reserved and status indices
        for (int i = 9; i < 15; i++) begin
            wr(4'(i), 8'hFF);
            rd(4'(i), b);
            chk("R3 write ignored", {24'h0, b}, 32'h0);
        end

        // R4: unused codes store but do not start
        wr32(4'd0, 32'h0005_0003);
        for (int c = 5; c < 8; c++) begin
            wr(4'd8, 8'(c));
            rd(4'd9, b);
            chk("R4 no start", {24'h0, b}, 32'h0);
            rd(4'd8, b);
            chk("R4 mode readback", {24'h0, b}, 32'(c));
        end
        rd32(4'd0, w);
        chk("R4 operands untouched", w, 32'h0005_0003);

        // R5: writes during busy are ignored
        wr32(4'd0, 32'd1000);
        wr32(4'd4, 32'd7);
        wr(4'd8, 8'h02);
        wr(4'd0, 8'h55);
        wr(4'd8, 8'h00);
        wr(4'd6, 8'h11);
        repeat (16) @(negedge clk);
        rd32(4'd0, w);
        chk("R5 quotient unaffected", w, 32'd142);
        rd32(4'd4, w);
        chk("R5 remainder unaffected", w, 32'd6);
        rd(4'd8, b);
        chk("R5 mode unaffected", {24'h0, b}, 32'h02);

        // R12: flag cleared by next start
        t_div(32'd5, 32'd0, 1'b0, 1'b1);
        t_mul(16'd3, 16'd4, 1'b0);

        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    t_mul(v16[i], v16[j], s[0]);

        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    t_div(v32[i], {16'h0, v16[j]}, s[0], 1'b0);
                    t_div(v32[i], v32[j], s[0], 1'b1);
                end

        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j += 2)
                    for (int k = 0; k < 8; k++)
                        t_mac(v16[i], v16[j + 1], v32[k], m[0], m[1]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule